// File: doc/BRIEF.md
# Hypercube Node Router

This block is the switching stage of one node in a binary hypercube of 2^DIM nodes. It has one link port per dimension plus a local port, so DIM+1 inputs and DIM+1 outputs in all. Every port uses a valid/ready handshake. A packet is one flit. It carries a DIM-bit destination node address and a payload word.

For each held packet the router takes the exclusive-or of the destination and its own node address, `self_id`. A set bit in that difference is a dimension the packet still has to cross. The router always sends the packet out on the lowest such dimension, so a given source and destination pair always follows the same path. The number of hops equals the number of set bits, and no path is longer than DIM. When the difference is zero, the packet has arrived and leaves through the local port.

Each input has a single packet register and each output has a single output register. The destination field is passed on unchanged, because every node recomputes the difference from its own address.

Top module: `hcube_node`

## Requirements
- R1: A packet whose destination differs from `self_id` leaves on output port k, where k is the lowest bit position at which the two addresses differ. Link port k is dimension k, for k = 0 to DIM-1.
- R2: A packet whose destination equals `self_id` leaves on output port DIM, the local port, and on no link port.
- R3: The destination address and the payload leave the router exactly as they entered.
- R4: After reset every `out_valid` is low. For an uncontested packet accepted at clock edge T, `out_valid` of its output port is high after edge T+1 and not before.
- R5: When several held packets want the same output in one cycle, the lowest-indexed input is granted. Each losing input keeps its packet and holds `in_ready` low until it is granted.
- R6: While `out_valid` is high and `out_ready` is low on a port, that port keeps `out_valid`, `out_dest` and `out_data` unchanged.
- R7: Each input holds at most one packet. `in_ready` is high when the input register is empty, or when its packet is granted in that cycle. Every accepted packet is delivered exactly once.
- R8: When its output is free, an input accepts a new packet on every clock edge, one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | DIM | Address of this node |
| in_valid | input | DIM+1 | Input packet present; bit k is link k, bit DIM is local injection |
| in_ready | output | DIM+1 | Input can take a packet this cycle |
| in_dest | input | (DIM+1)*DIM | Destination address per input, port p at bits p*DIM upward |
| in_data | input | (DIM+1)*DW | Payload per input, port p at bits p*DW upward |
| out_valid | output | DIM+1 | Output packet present; bit k is link k, bit DIM is local ejection |
| out_ready | input | DIM+1 | Downstream accepts the output packet |
| out_dest | output | (DIM+1)*DIM | Destination address per output |
| out_data | output | (DIM+1)*DW | Payload per output |

## Verification
Two things can happen to the same output in the same cycle: arbitration between inputs competing for it, and back-pressure from a stalled receiver. A directed case injects two packets bound for one link in the same cycle. It checks that the lower input wins, that the loser's ready stays low, and that the two payloads come out in order. A stalled local port is then loaded from two inputs while a third packet waits, so that the hold, blocking and release behaviour all overlap. Finally, all inputs send to every destination at once under two node addresses. Contention and back-to-back draining then overlap, and a scoreboard matches each payload to its expected port and destination.

// File: rtl/hcube_pkg.sv
package hcube_pkg;
  // isolate the lowest set bit of a vector (priority pick, bit 0 first)
  function automatic logic [31:0] iso_low(input logic [31:0] v);
    return v & (~v + 32'd1);
  endfunction
endpackage

// File: rtl/hcube_inbuf.sv
module hcube_inbuf #(
  parameter int DIM = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DIM-1:0] in_dest,
  input  logic [DW-1:0]  in_data,
  input  logic           pop,
  output logic           held,
  output logic [DIM-1:0] h_dest,
  output logic [DW-1:0]  h_data
);
  assign in_ready = !held || pop;

  always_ff @(posedge clk) begin
    if (rst)                        held <= 1'b0;
    else if (in_valid && in_ready)  held <= 1'b1;
    else if (pop)                   held <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      h_dest <= in_dest;
      h_data <= in_data;
    end
  end
endmodule

// File: rtl/hcube_route.sv
module hcube_route
  import hcube_pkg::*;
#(
  parameter int DIM = 3
) (
  input  logic           valid,
  input  logic [DIM-1:0] self_id,
  input  logic [DIM-1:0] dest,
  output logic [DIM:0]   req
);
  logic [DIM-1:0] diff;
  logic [31:0]    low;

  assign diff = dest ^ self_id;
  assign low  = iso_low(32'(diff));
  assign req[DIM-1:0] = valid ? low[DIM-1:0] : '0;
  assign req[DIM]     = valid && (diff == '0);
endmodule

// File: rtl/hcube_outarb.sv
module hcube_outarb
  import hcube_pkg::*;
#(
  parameter int P = 4
) (
  input  logic         free,
  input  logic [P-1:0] req,
  output logic [P-1:0] gnt
);
  logic [31:0] low;

  assign low = iso_low(32'(req));
  assign gnt = free ? low[P-1:0] : '0;
endmodule

// File: rtl/hcube_node.sv
module hcube_node #(
  parameter int DIM = 3,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DIM-1:0]         self_id,
  input  logic [DIM:0]           in_valid,
  output logic [DIM:0]           in_ready,
  input  logic [(DIM+1)*DIM-1:0] in_dest,
  input  logic [(DIM+1)*DW-1:0]  in_data,
  output logic [DIM:0]           out_valid,
  input  logic [DIM:0]           out_ready,
  output logic [(DIM+1)*DIM-1:0] out_dest,
  output logic [(DIM+1)*DW-1:0]  out_data
);
  localparam int P = DIM + 1;

  logic [P-1:0]   held;
  logic [P-1:0]   pop;
  logic [DIM-1:0] h_dest [P];
  logic [DW-1:0]  h_data [P];
  logic [P-1:0]   req    [P];   // req[input][output]
  logic [P-1:0]   gnt    [P];   // gnt[output][input]

  for (genvar i = 0; i < P; i++) begin : g_in
    hcube_inbuf #(.DIM(DIM), .DW(DW)) u_buf (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid[i]),
      .in_ready (in_ready[i]),
      .in_dest  (in_dest[i*DIM +: DIM]),
      .in_data  (in_data[i*DW +: DW]),
      .pop      (pop[i]),
      .held     (held[i]),
      .h_dest   (h_dest[i]),
      .h_data   (h_data[i])
    );

    hcube_route #(.DIM(DIM)) u_rt (
      .valid   (held[i]),
      .self_id (self_id),
      .dest    (h_dest[i]),
      .req     (req[i])
    );
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < P; o++)
      for (int i = 0; i < P; i++)
        pop[i] = pop[i] | gnt[o][i];
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    logic [P-1:0]   col;
    logic           free;
    logic           vld_q;
    logic [DIM-1:0] dst_q, dst_n;
    logic [DW-1:0]  dat_q, dat_n;

    always_comb begin
      for (int i = 0; i < P; i++) col[i] = req[i][o];
    end

    assign free = !vld_q || out_ready[o];

    hcube_outarb #(.P(P)) u_arb (
      .free (free),
      .req  (col),
      .gnt  (gnt[o])
    );

    always_comb begin
      dst_n = '0;
      dat_n = '0;
      for (int i = 0; i < P; i++) begin
        if (gnt[o][i]) begin
          dst_n = h_dest[i];
          dat_n = h_data[i];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)       vld_q <= 1'b0;
      else if (free) vld_q <= |gnt[o];
    end

    always_ff @(posedge clk) begin
      if (|gnt[o]) begin
        dst_q <= dst_n;
        dat_q <= dat_n;
      end
    end

    assign out_valid[o]            = vld_q;
    assign out_dest[o*DIM +: DIM]  = dst_q;
    assign out_data[o*DW +: DW]    = dat_q;
  end
endmodule

// File: rtl/hcube_node_chk.sv
module hcube_node_chk #(
  parameter int DIM = 3,
  parameter int DW  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [DIM-1:0]         self_id,
  input logic [DIM:0]           out_valid,
  input logic [DIM:0]           out_ready,
  input logic [(DIM+1)*DIM-1:0] out_dest,
  input logic [(DIM+1)*DW-1:0]  out_data
);
  localparam int P = DIM + 1;

  for (genvar o = 0; o < P; o++) begin : g_port
    logic [DIM-1:0] dx;
    assign dx = out_dest[o*DIM +: DIM] ^ self_id;

    p_hold_valid_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] && !out_ready[o] |=> out_valid[o]);

    p_hold_fields_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] && !out_ready[o] |=>
        $stable(out_data[o*DW +: DW]) && $stable(out_dest[o*DIM +: DIM]));

    if (o < DIM) begin : g_link
      localparam logic [DIM-1:0] LOWER = DIM'((1 << o) - 1);
      // R1: a link output only carries packets whose lowest differing bit is its own dimension
      p_link_dim_r1: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] |-> (dx[o] && ((dx & LOWER) == '0)));
    end else begin : g_local
      p_local_dest_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid[o] |-> (out_dest[o*DIM +: DIM] == self_id));
    end
  end
endmodule

bind hcube_node hcube_node_chk #(.DIM(DIM), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .self_id   (self_id),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_dest  (out_dest),
  .out_data  (out_data)
);

// File: tb/sim_hcube_node.sv
`timescale 1ns/1ps
module sim_hcube_node;
  localparam int DIM = 3;
  localparam int DW  = 8;
  localparam int P   = DIM + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst;
  logic [DIM-1:0]       self_id;
  logic [P-1:0]         in_valid, in_ready, out_valid, out_ready;
  logic [P*DIM-1:0]     in_dest, out_dest;
  logic [P*DW-1:0]      in_data, out_data;

  hcube_node #(.DIM(DIM), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .self_id(self_id),
    .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_dest(out_dest), .out_data(out_data)
  );

  typedef struct packed {
    logic [7:0]     port;
    logic [DIM-1:0] dest;
    logic [DW-1:0]  data;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails  = 0;
  int          cyc    = 0;
  logic [DW-1:0] tag  = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_port(input logic [DIM-1:0] d);
    logic [DIM-1:0] x;
    x = d ^ self_id;
    if (x == '0) return DIM;
    for (int b = 0; b < DIM; b++) if (x[b]) return b;
    return DIM;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic send(input int i, input logic [DIM-1:0] d, output logic [DW-1:0] dv);
    bit ok;
    dv  = tag;
    tag = tag + 1'b1;
    sb.push_back('{8'(exp_port(d)), d, dv});
    @(negedge clk);
    in_valid[i] = 1'b1;
    in_dest[i*DIM +: DIM] = d;
    in_data[i*DW +: DW]   = dv;
    forever begin
      #1 ok = in_ready[i];
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    #1 in_valid[i] = 1'b0;
  endtask

  task automatic sample();
    @(negedge clk);
    #1;
  endtask

  // monitor: pops matching scoreboard entries as outputs hand off
  initial begin
    logic [DW-1:0] dv;
    int idx;
    forever begin
      @(negedge clk);
      #1;
      if (!rst) begin
        for (int o = 0; o < P; o++) begin
          if (out_valid[o] && out_ready[o]) begin
            dv  = out_data[o*DW +: DW];
            idx = -1;
            foreach (sb[k]) if (idx < 0 && sb[k].data == dv) idx = k;
            chk(idx >= 0, "R7", "delivered tag known and not yet delivered", int'(dv), int'(dv));
            if (idx >= 0) begin
              if (sb[idx].port == DIM)
                chk(o == DIM, "R2", "local packet port", o, int'(sb[idx].port));
              else
                chk(o == int'(sb[idx].port), "R1", "link port for tag", o, int'(sb[idx].port));
              chk(out_dest[o*DIM +: DIM] == sb[idx].dest, "R3", "dest unchanged",
                  int'(out_dest[o*DIM +: DIM]), int'(sb[idx].dest));
              sb.delete(idx);
            end
          end
        end
      end
    end
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic drain(input string rq);
    for (int n = 0; n < 60 && sb.size() != 0; n++) sample();
    chk(sb.size() == 0, rq, "all packets delivered", sb.size(), 0);
  endtask

  task automatic sweep();
    for (int i = 0; i < P; i++) begin
      fork
        automatic int ii = i;
        begin
          logic [DW-1:0] dvx;
          for (int d = 0; d < (1 << DIM); d++) send(ii, DIM'(d), dvx);
        end
      join_none
    end
    wait fork;
    drain("R7");
  endtask

  initial begin
    logic [DW-1:0] a, b, c;
    int c0, c3;
    in_valid = '0; in_dest = '0; in_data = '0; out_ready = '1;
    self_id = 3'b101; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    chk(out_valid == '0, "R4", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '1, "R7", "in_ready after reset", int'(in_ready), 15);

    // R4 latency, link 1 (111 ^ 101 = 010)
    send(0, 3'b111, a);
    sample();
    chk(out_valid[1] == 1'b0, "R4", "out_valid one cycle after accept", int'(out_valid[1]), 0);
    sample();
    chk(out_valid[1] == 1'b1, "R4", "out_valid two cycles after accept", int'(out_valid[1]), 1);
    chk(out_data[1*DW +: DW] == a, "R3", "payload unchanged", int'(out_data[1*DW +: DW]), int'(a));
    drain("R4");

    // R2 local delivery from a link input
    send(2, self_id, a);
    drain("R2");

    // R5 contention: inputs 1 and 2 both to link 0 (100 ^ 101 = 001)
    fork
      send(1, 3'b100, a);
      send(2, 3'b100, b);
    join
    sample();
    chk(in_ready[2] == 1'b0, "R5", "losing input ready", int'(in_ready[2]), 0);
    chk(in_ready[1] == 1'b1, "R5", "winning input ready", int'(in_ready[1]), 1);
    sample();
    chk(out_data[0 +: DW] == a, "R5", "first winner payload", int'(out_data[0 +: DW]), int'(a));
    sample();
    chk(out_data[0 +: DW] == b, "R5", "second payload", int'(out_data[0 +: DW]), int'(b));
    drain("R5");

    // R6/R7: stalled local port
    @(negedge clk) out_ready[DIM] = 1'b0;
    send(0, self_id, a);
    send(1, self_id, b);
    sample(); sample();
    chk(out_valid[DIM] == 1'b1, "R6", "stalled valid", int'(out_valid[DIM]), 1);
    chk(out_data[DIM*DW +: DW] == a, "R6", "stalled payload", int'(out_data[DIM*DW +: DW]), int'(a));
    chk(in_ready[1] == 1'b0, "R7", "full input ready", int'(in_ready[1]), 0);
    fork
      send(1, self_id, c);
    join_none
    sample(); sample(); sample();
    chk(in_ready[1] == 1'b0, "R7", "blocked input ready", int'(in_ready[1]), 0);
    chk(out_data[DIM*DW +: DW] == a, "R6", "payload still held", int'(out_data[DIM*DW +: DW]), int'(a));
    @(negedge clk) out_ready[DIM] = 1'b1;
    wait fork;
    drain("R6");

    // R8: back-to-back on input 3 to link 2 (001 ^ 101 = 100)
    send(3, 3'b001, a);
    c0 = cyc;
    send(3, 3'b001, a);
    send(3, 3'b001, a);
    send(3, 3'b001, a);
    c3 = cyc;
    chk(c3 - c0 == 3, "R8", "cycles for three more accepts", c3 - c0, 3);
    drain("R8");

    // all inputs, all destinations, two node addresses
    sweep();
    @(negedge clk) rst = 1'b1;
    self_id = 3'b010;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sweep();
    send(3, 3'b011, a);  // 011 ^ 010 = 001 -> link 0, R1
    drain("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule